// File: doc/BRIEF.md
# Mixed-Width Memory Serializer

This block turns a stream of wide parallel packets into a narrow serial sample stream. It does this with a dual-port memory whose two ports have different widths. Each packet is a 32-bit word made of sixteen 2-bit samples. A producer writes one packet on each strobe of a write enable that pulses once every sixteen cycles of the fast clock. The read port is one sample wide. An internal read-address counter steps through every sample of every stored word, one sample per fast cycle. The memory's own sub-word select therefore does the serializing, and no separate shift register follows the storage.

The read address is four bits wider than the write address. Its upper bits pick the stored word and its four low bits pick the sample inside that word. The read side trails the write side by one whole word: it starts on a word only after that word has been stored, and it reads words in the order they were written. A count of words that are stored but not yet read lets the writer run ahead in bursts of up to the memory depth, and the reader then catches up. Both ports run on one clock. The read output is registered, and its valid flag is delayed to match.

Top module: `mwram_serializer`

## Requirements
- R1: On a cycle with `wr_strobe` high, the block stores `wr_word` at the next write address. Write addresses run 0 to 255 and wrap back to 0.
- R2: Samples from one word come out in index order. Sample 0 (bits [1:0]) is first and sample 15 (bits [31:30]) is last. Words come out in the order they were written.
- R3: When the reader is idle, the first sample of a word written at a clock edge is presented with `rd_valid` high right after the next clock edge.
- R4: With one strobe every sixteen cycles, `rd_valid` stays high with no gap from the first sample onward, until the last written sample has been delivered.
- R5: Once every written sample has been delivered, `rd_valid` drops low. `rd_sample` holds the last delivered sample while `rd_valid` is low.
- R6: Strobes that come faster than one per sixteen cycles are backlogged, up to 256 words. Every sample is delivered in order, with none lost or repeated.
- R7: A synchronous active-low reset clears both address counters and the backlog, drives `rd_valid` and `rd_sample` to 0, and makes the next written word the first one delivered.
- R8: The stream stays correct after more than 256 words, when the read address wraps from 4095 back to 0.
- R9: `rd_valid` is never high unless a written sample is still waiting to be delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_strobe | input | 1 | Slow-rate write enable, one cycle wide |
| wr_word | input | 32 | Packed word of sixteen 2-bit samples |
| rd_sample | output | 2 | Serial sample output (registered) |
| rd_valid | output | 1 | High when rd_sample carries a new sample |

## Verification
The bench targets the sample order inside a word. A design with the sub-word select reversed or offset would emit the samples in the wrong order, and the scoreboard would catch each misplaced sample. It checks the one-cycle latency and a gap-free stream at the nominal 1:16 rate. A reader that started one word late, or that stalled at word boundaries, would show a missing or stray valid cycle. Back-to-back bursts exercise the backlog, where a miscounted backlog would drop or repeat words. A run of more than 256 words crosses the address wrap, and a reset in the middle of a stream must leave no stale samples behind.

// File: rtl/mwser_pkg.sv
// Package: default geometry shared by the serializer modules.
// Assumes samples are packed little-end first inside each stored word.
package mwser_pkg;
    localparam int DEF_SAMPLE_W = 2;   // bits per sample
    localparam int DEF_SAMPLES  = 16;  // samples per stored word
    localparam int DEF_WADDR_W  = 8;   // word address width
endpackage

// File: rtl/mwser_wr_ctrl.sv
// Write-side controller: turns the slow strobe into a write enable and
// keeps the word address, which wraps freely at the memory depth.
// Assumes the strobe is one cycle wide and occurs at most once per cycle.
module mwser_wr_ctrl #(
    parameter int WADDR_W = mwser_pkg::DEF_WADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_strobe,
    output logic               wr_en,
    output logic [WADDR_W-1:0] wr_addr
);
    assign wr_en = wr_strobe;

    // Advance the word address after each accepted write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wr_addr <= '0;
        else if (wr_strobe)
            wr_addr <= wr_addr + 1'b1;
    end
endmodule

// File: rtl/mwser_rd_seq.sv
// Read sequencer: counts words stored but not yet read, and issues one
// sample read per cycle while that count is non-zero. The read address
// trails the write address by one full word.
// Assumes the writer never runs more than the memory depth ahead.
module mwser_rd_seq #(
    parameter int WADDR_W = mwser_pkg::DEF_WADDR_W,
    parameter int SEL_W   = 4,
    localparam int RADDR_W = WADDR_W + SEL_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_strobe,
    output logic               rd_go,
    output logic [RADDR_W-1:0] rd_addr
);
    logic [WADDR_W:0] backlog;
    logic             word_done;

    assign rd_go     = (backlog != '0);
    assign word_done = rd_go && (rd_addr[SEL_W-1:0] == {SEL_W{1'b1}});

    // Track stored-but-unread words: +1 on a write, -1 on a finished word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            backlog <= '0;
        else begin
            case ({wr_strobe, word_done})
                2'b10:   backlog <= backlog + 1'b1;
                2'b01:   backlog <= backlog - 1'b1;
                default: backlog <= backlog;
            endcase
        end
    end

    // Step the sample address once per issued read; wraps at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_addr <= '0;
        else if (rd_go)
            rd_addr <= rd_addr + 1'b1;
    end
endmodule

// File: rtl/mwser_mem.sv
// Mixed-width storage: a wide write port and a narrow read port. The
// upper read-address bits pick a word, the low bits pick a sample in
// it. The read data and its valid flag are registered, so a read that
// collides with a write to the same word returns the old contents.
module mwser_mem #(
    parameter int SAMPLE_W = mwser_pkg::DEF_SAMPLE_W,
    parameter int SAMPLES  = mwser_pkg::DEF_SAMPLES,
    parameter int WADDR_W  = mwser_pkg::DEF_WADDR_W,
    localparam int SEL_W   = $clog2(SAMPLES),
    localparam int RADDR_W = WADDR_W + SEL_W,
    localparam int DEPTH   = 1 << WADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [WADDR_W-1:0]               wr_addr,
    input  logic [SAMPLES-1:0][SAMPLE_W-1:0] wr_data,
    input  logic                             rd_en,
    input  logic [RADDR_W-1:0]               rd_addr,
    output logic [SAMPLE_W-1:0]              rd_data,
    output logic                             rd_valid
);
    logic [SAMPLES-1:0][SAMPLE_W-1:0] store [DEPTH];
    logic [SAMPLES-1:0][SAMPLE_W-1:0] rd_word;
    logic [WADDR_W-1:0]               rd_word_idx;
    logic [SEL_W-1:0]                 rd_sel;

    assign rd_word_idx = rd_addr[RADDR_W-1:SEL_W];
    assign rd_sel      = rd_addr[SEL_W-1:0];
    assign rd_word     = store[rd_word_idx];

    // Wide write port: store one packed word.
    always_ff @(posedge clk) begin
        if (wr_en)
            store[wr_addr] <= wr_data;
    end

    // Narrow read port: register the selected sample and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en)
                rd_data <= rd_word[rd_sel];
        end
    end
endmodule

// File: rtl/mwram_serializer.sv
// Top: parallel-to-serial converter built on a mixed-width memory.
// Words arrive on a slow strobe and leave one sample per clock.
// Assumes one clock for both ports and a writer rate at or below the
// reader rate on average, with bursts no deeper than the memory.
module mwram_serializer #(
    parameter int SAMPLE_W = mwser_pkg::DEF_SAMPLE_W,
    parameter int SAMPLES  = mwser_pkg::DEF_SAMPLES,
    parameter int WADDR_W  = mwser_pkg::DEF_WADDR_W,
    localparam int WORD_W  = SAMPLE_W * SAMPLES,
    localparam int SEL_W   = $clog2(SAMPLES),
    localparam int RADDR_W = WADDR_W + SEL_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_strobe,
    input  logic [WORD_W-1:0]   wr_word,
    output logic [SAMPLE_W-1:0] rd_sample,
    output logic                rd_valid
);
    logic               wr_en;
    logic [WADDR_W-1:0] wr_addr;
    logic               rd_go;
    logic [RADDR_W-1:0] rd_addr;

    mwser_wr_ctrl #(.WADDR_W(WADDR_W)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_strobe(wr_strobe),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr)
    );

    mwser_rd_seq #(.WADDR_W(WADDR_W), .SEL_W(SEL_W)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_strobe(wr_strobe),
        .rd_go    (rd_go),
        .rd_addr  (rd_addr)
    );

    mwser_mem #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES), .WADDR_W(WADDR_W)) u_mem (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_word),
        .rd_en   (rd_go),
        .rd_addr (rd_addr),
        .rd_data (rd_sample),
        .rd_valid(rd_valid)
    );
endmodule

// File: rtl/mwser_checker.sv
// Checker: observes the serializer ports and keeps its own count of
// samples owed to the output, independent of the design's counters.
module mwser_checker #(
    parameter int SAMPLE_W = mwser_pkg::DEF_SAMPLE_W,
    parameter int SAMPLES  = mwser_pkg::DEF_SAMPLES
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_strobe,
    input logic [SAMPLE_W-1:0] rd_sample,
    input logic                rd_valid
);
    logic [31:0] owed;

    // Samples written minus samples delivered.
    always_ff @(posedge clk) begin
        if (!rst_n)
            owed <= '0;
        else
            owed <= owed + (wr_strobe ? 32'(SAMPLES) : 32'd0) - (rd_valid ? 32'd1 : 32'd0);
    end

    // R7: reset forces the output idle and cleared on the next cycle.
    assert_reset_clears_R7: assert property (@(posedge clk)
        !rst_n |=> (!rd_valid && rd_sample == '0));

    // R9: a valid sample must correspond to a written, undelivered one.
    assert_valid_needs_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (owed != 0));

    // R3: a write is followed by a valid sample two edges later.
    assert_write_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |=> ##1 rd_valid);

    // R5: the output holds while invalid.
    assert_hold_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_valid && $past(rst_n)) |-> $stable(rd_sample));
endmodule

bind mwram_serializer mwser_checker #(.SAMPLE_W(SAMPLE_W), .SAMPLES(SAMPLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_strobe(wr_strobe),
    .rd_sample(rd_sample),
    .rd_valid (rd_valid)
);

// File: tb/test_mwram_serializer.sv
`timescale 1ns/1ps
module test_mwram_serializer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic [31:0] wr_word = '0;
    logic [1:0]  rd_sample;
    logic        rd_valid;

    int n_checks = 0;
    int n_errs   = 0;
    logic [1:0] exp_q [$];
    string      tag_q [$];

    always #2 clk = ~clk;   // 250 MHz

    mwram_serializer i_mwram_serializer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_strobe(wr_strobe),
        .wr_word  (wr_word),
        .rd_sample(rd_sample),
        .rd_valid (rd_valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int k);
        return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
    endfunction

    // Driver: call at a negedge; one strobe cycle, pushes 16 expected samples.
    task automatic write_word(input logic [31:0] d, input string tag);
        wr_strobe = 1'b1;
        wr_word   = d;
        @(posedge clk);
        for (int i = 0; i < 16; i++) begin
            exp_q.push_back(d[2*i +: 2]);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        wr_strobe = 1'b0;
    endtask

    // Monitor: compare each valid sample against the scoreboard head.
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9", "valid with nothing owed", 1, 0);
            end else begin
                logic [1:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_sample == e, t, "sample order R2", int'(rd_sample), int'(e));
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        n_errs++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check(rd_valid == 1'b0, "R7", "valid in reset", int'(rd_valid), 0);
        check(rd_sample == 2'd0, "R7", "sample in reset", int'(rd_sample), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Single word: latency, then idle hold.
        d = 32'hE4E4_1B1B;
        write_word(d, "R2");
        check(rd_valid == 1'b0, "R3", "valid too early", int'(rd_valid), 0);
        @(negedge clk);
        check(rd_valid == 1'b1, "R3", "first sample valid", int'(rd_valid), 1);
        check(rd_sample == d[1:0], "R3", "first sample value", int'(rd_sample), int'(d[1:0]));
        repeat (16) @(negedge clk);
        check(rd_valid == 1'b0, "R5", "valid after drain", int'(rd_valid), 0);
        check(rd_sample == d[31:30], "R5", "held sample", int'(rd_sample), int'(d[31:30]));

        // Nominal 1:16 rate: gap-free stream.
        for (int k = 0; k < 8; k++) begin
            d = mk(k);
            write_word(d, "R1");
            if (k > 0)
                check(rd_valid == 1'b1, "R4", "gap at word start", int'(rd_valid), 1);
            for (int j = 0; j < 15; j++) begin
                @(negedge clk);
                check(rd_valid == 1'b1, "R4", "gap inside stream", int'(rd_valid), 1);
            end
        end
        @(negedge clk);
        check(rd_valid == 1'b1, "R4", "last sample valid", int'(rd_valid), 1);
        @(negedge clk);
        check(rd_valid == 1'b0, "R5", "valid after stream", int'(rd_valid), 0);
        check(rd_sample == d[31:30], "R5", "held last sample", int'(rd_sample), int'(d[31:30]));

        // Back-to-back burst builds a backlog.
        for (int k = 0; k < 24; k++)
            write_word(mk(100 + k), "R6");
        repeat (24 * 16 + 4) @(negedge clk);
        check(exp_q.size() == 0, "R6", "samples left after burst", exp_q.size(), 0);
        check(rd_valid == 1'b0, "R6", "valid after burst", int'(rd_valid), 0);

        // Reset in mid-stream.
        for (int k = 0; k < 3; k++)
            write_word(mk(200 + k), "R7");
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(rd_valid == 1'b0, "R7", "valid after reset", int'(rd_valid), 0);
        check(rd_sample == 2'd0, "R7", "sample after reset", int'(rd_sample), 0);
        exp_q.delete();
        tag_q.delete();
        rst_n = 1'b1;
        @(negedge clk);
        write_word(32'h1234_5678, "R7");
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R7", "samples left after reset", exp_q.size(), 0);

        // Address wrap: more than 256 words.
        for (int k = 0; k < 300; k++) begin
            write_word(mk(1000 + k), "R8");
            repeat (15) @(negedge clk);
        end
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8", "samples left after wrap", exp_q.size(), 0);
        check(rd_valid == 1'b0, "R8", "valid after wrap", int'(rd_valid), 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule